// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block drives one DMA data transfer between an IDE drive and a descriptor-based DMA channel. The drive side starts a transfer by pulsing `start` together with the device type, the command, the block address and the size. The sequencer loads the remaining byte count, clears its progress index, raises `dma_active` and kicks the DMA channel for one cycle.

The channel then offers chunks, one descriptor at a time, through a request/acknowledge handshake. For each chunk the sequencer computes the media byte offset and issues one storage request. It then waits for the storage side to acknowledge or to report an error, and retires the chunk. Disks address the medium in 512-byte sectors and packet devices in 2048-byte blocks. A packet device can also run in a byte mode that is not block-based: the transfer then finishes after a single step.

A chunk offered before a transfer has started is not consumed; the sequencer signals a stall so the channel can wait to be restarted. A flush request is answered only while no storage request is outstanding.

Top module: `ide_dma_sequencer`

## Requirements
- R1: A `start` pulse while idle raises `dma_active` and pulses `kick` in the following cycle, and clears the progress index to zero. A `start` seen while `dma_active` is high is ignored: no kick, and the latched parameters do not change.
- R2: The remaining count loads `sector_count * 512` for a disk (`dev_packet`=0) and `packet_bytes` for a packet device (`dev_packet`=1).
- R3: Each issued chunk carries `store_off` = (`lba` << 9) + index for a disk and (`lba` << 11) + index for a packet device. `store_len` equals `chunk_len`, and the index grows by each issued length.
- R4: While `dma_active` is low, a held `chunk_req` pulses `chunk_stall` each cycle. It produces neither `store_req` nor `chunk_ack`.
- R5: `store_req` stays high, with `store_off`, `store_len` and `store_dir` stable, until `store_ack` or `store_err`. `chunk_ack` pulses in the cycle after `store_ack`.
- R6: `store_dir` is 0 (from the device) for `op_code` 0 (read) and for any packet device. It is 1 (toward the device) for disk `op_code` 1 (write) and 2 (trim).
- R7: When the remaining count is at or below zero, either after an acknowledged chunk or at a chunk request, the sequencer pulses `done` and `chunk_ack` for one cycle and drops `dma_active`. `status_ready` is then set for a disk and stays clear for a packet device.
- R8: In packet byte mode (`dev_packet`=1, `packet_blocks`=0), the single storage request has length min(remaining, `chunk_len`), and `done` follows its acknowledge.
- R9: `store_err` aborts the transfer: `error` and `chunk_ack` pulse for one cycle, `dma_active` drops, and neither `done` nor `status_ready` is raised.
- R10: `flush_ack` is high only in the cycle after a cycle in which `flush_req` was high and no storage request was outstanding.
- R11: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Drive side starts a transfer |
| dev_packet | input | 1 | 1 = packet device, 0 = disk |
| packet_blocks | input | 1 | Packet device: 1 = block-based, 0 = byte mode |
| op_code | input | 2 | Disk command: 0 read, 1 write, 2 trim |
| lba | input | LBA_W | Starting block address |
| sector_count | input | SECT_W | Disk sector count |
| packet_bytes | input | PKT_W | Packet transfer size in bytes |
| kick | output | 1 | One-cycle pulse that restarts the DMA channel |
| dma_active | output | 1 | Transfer in progress |
| chunk_req | input | 1 | Channel offers a descriptor chunk (held until acknowledged) |
| chunk_len | input | LEN_W | Chunk length in bytes |
| chunk_ack | output | 1 | Chunk retired |
| chunk_stall | output | 1 | Chunk refused because no transfer is active |
| store_req | output | 1 | Storage request outstanding |
| store_dir | output | 1 | 1 = toward the device, 0 = from the device |
| store_off | output | OFF_W | Media byte offset |
| store_len | output | LEN_W | Request length in bytes |
| store_ack | input | 1 | Storage side completed the request |
| store_err | input | 1 | Storage side reports an error |
| flush_req | input | 1 | Flush request |
| flush_ack | output | 1 | Flush granted |
| done | output | 1 | One-cycle normal-completion pulse |
| error | output | 1 | One-cycle abort pulse |
| status_ready | output | 1 | Disk ready and seek complete after completion |

## Verification
The offset and length path is exercised with disk reads, writes and trims, and with block-based packet transfers at several block addresses. These separate the 9-bit shift from the 11-bit shift and show that the index accumulates across chunks. Chunks larger than the remaining count, a zero-length disk transfer and packet byte mode tell the completion checks apart: completion after an acknowledge, completion at the request, and the min() clamp. Random transfers mix all device types, commands and chunk sizes against a bench model of remaining count and index. Directed cases cover a chunk refused before start, a start during a transfer, an error abort and a flush held off by a pending request.

// File: rtl/idedma_pkg.sv
// Shared types and constants for the IDE DMA transfer sequencer.
// Assumes: command codes are fixed by the drive side's command decode.
package idedma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_XFER = 2'd2
    } seq_state_t;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_TRIM  = 2'd2;

    localparam int DISK_SHIFT = 9;
    localparam int PKT_SHIFT  = 11;

endpackage

// File: rtl/idedma_progress.sv
// Remaining byte count and progress index of one transfer.
// Assumes: load and step are never high together in a way that matters;
// load wins. The remaining count is signed, so an oversize last chunk
// drives it below zero.
module idedma_progress #(
    parameter int REM_W = 19,
    parameter int IDX_W = 20,
    parameter int LEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [REM_W-1:0]        load_val,
    input  logic                    step,
    input  logic [LEN_W-1:0]        step_len,
    output logic signed [REM_W-1:0] rem,
    output logic [IDX_W-1:0]        idx,
    output logic                    rem_le0
);

    logic [REM_W-1:0] ext_len;

    // Zero-extend the chunk length to the count width.
    always_comb ext_len = {{(REM_W-LEN_W){1'b0}}, step_len};

    // Load on start, otherwise move bytes from remaining to index per chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            idx <= '0;
        end else if (load) begin
            rem <= $signed(load_val);
            idx <= '0;
        end else if (step) begin
            rem <= rem - $signed(ext_len);
            idx <= idx + IDX_W'(step_len);
        end
    end

    // Transfer end test: remaining at or below zero.
    always_comb rem_le0 = rem[REM_W-1] || (rem == '0);

    AST_IDX_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (idx == '0)); // R1

    AST_IDX_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (idx >= $past(idx))); // R3

endmodule

// File: rtl/idedma_offset.sv
// Media byte offset: block address scaled by device granularity plus index.
// Assumes: OFF_W leaves room for the packet shift and the index carry.
module idedma_offset #(
    parameter int LBA_W = 20,
    parameter int IDX_W = 20,
    parameter int OFF_W = 32
) (
    input  logic             is_pkt,
    input  logic [LBA_W-1:0] lba,
    input  logic [IDX_W-1:0] idx,
    output logic [OFF_W-1:0] off
);
    import idedma_pkg::*;

    logic [OFF_W-1:0] lba_w;
    logic [OFF_W-1:0] base;

    // Scale the block address by the device's block size and add the index.
    always_comb begin
        lba_w = OFF_W'(lba);
        base  = is_pkt ? (lba_w << PKT_SHIFT) : (lba_w << DISK_SHIFT);
        off   = base + OFF_W'(idx);
    end

endmodule

// File: rtl/ide_dma_sequencer.sv
// Top of the IDE DMA transfer sequencer. Accepts a start from the drive
// side, services descriptor chunks from the DMA channel one at a time,
// issues one storage request per chunk and signals completion or abort.
// Assumes: chunk_req is held until chunk_ack; the storage side answers each
// request with exactly one store_ack or store_err.
module ide_dma_sequencer #(
    parameter  int LBA_W  = 20,
    parameter  int SECT_W = 8,
    parameter  int PKT_W  = 16,
    parameter  int LEN_W  = 16,
    localparam int OFF_W  = LBA_W + 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dev_packet,
    input  logic              packet_blocks,
    input  logic [1:0]        op_code,
    input  logic [LBA_W-1:0]  lba,
    input  logic [SECT_W-1:0] sector_count,
    input  logic [PKT_W-1:0]  packet_bytes,
    output logic              kick,
    output logic              dma_active,
    input  logic              chunk_req,
    input  logic [LEN_W-1:0]  chunk_len,
    output logic              chunk_ack,
    output logic              chunk_stall,
    output logic              store_req,
    output logic              store_dir,
    output logic [OFF_W-1:0]  store_off,
    output logic [LEN_W-1:0]  store_len,
    input  logic              store_ack,
    input  logic              store_err,
    input  logic              flush_req,
    output logic              flush_ack,
    output logic              done,
    output logic              error,
    output logic              status_ready
);
    import idedma_pkg::*;

    localparam int SIZE_W = (PKT_W > SECT_W + 9) ? PKT_W : SECT_W + 9;
    localparam int REM_W  = SIZE_W + 2;
    localparam int IDX_W  = REM_W + 1;

    seq_state_t               state;
    logic                     pkt_q;
    logic                     bytemode_q;
    logic [LBA_W-1:0]         lba_q;
    logic                     start_go;
    logic                     take;
    logic                     issue;
    logic [LEN_W-1:0]         issue_len;
    logic [REM_W-1:0]         load_val;
    logic signed [REM_W-1:0]  rem;
    logic [IDX_W-1:0]         idx;
    logic                     rem_le0;
    logic [OFF_W-1:0]         cur_off;
    logic signed [REM_W-1:0]  len_s;

    // Accept conditions for a start and for a fresh chunk.
    always_comb begin
        start_go = start && (state == ST_IDLE);
        take     = (state == ST_RUN) && chunk_req && !chunk_ack;
        issue    = take && !rem_le0;
    end

    // Initial byte count by device type.
    always_comb load_val = dev_packet ? REM_W'(packet_bytes)
                                      : REM_W'({sector_count, 9'b0});

    // Chunk length, clamped to the remainder in packet byte mode.
    always_comb begin
        len_s = $signed({{(REM_W-LEN_W){1'b0}}, chunk_len});
        if (bytemode_q && (len_s > rem))
            issue_len = rem[LEN_W-1:0];
        else
            issue_len = chunk_len;
    end

    idedma_progress #(
        .REM_W (REM_W),
        .IDX_W (IDX_W),
        .LEN_W (LEN_W)
    ) u_progress (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_go),
        .load_val (load_val),
        .step     (issue),
        .step_len (issue_len),
        .rem      (rem),
        .idx      (idx),
        .rem_le0  (rem_le0)
    );

    idedma_offset #(
        .LBA_W (LBA_W),
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) u_offset (
        .is_pkt (pkt_q),
        .lba    (lba_q),
        .idx    (idx),
        .off    (cur_off)
    );

    // Transfer state machine and all registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            pkt_q        <= 1'b0;
            bytemode_q   <= 1'b0;
            lba_q        <= '0;
            kick         <= 1'b0;
            chunk_ack    <= 1'b0;
            chunk_stall  <= 1'b0;
            store_req    <= 1'b0;
            store_dir    <= 1'b0;
            store_off    <= '0;
            store_len    <= '0;
            flush_ack    <= 1'b0;
            done         <= 1'b0;
            error        <= 1'b0;
            status_ready <= 1'b0;
        end else begin
            kick        <= 1'b0;
            chunk_ack   <= 1'b0;
            chunk_stall <= 1'b0;
            done        <= 1'b0;
            error       <= 1'b0;
            flush_ack   <= flush_req && !store_req;
            unique case (state)
                ST_IDLE: begin
                    chunk_stall <= chunk_req && !chunk_ack;
                    if (start) begin
                        state        <= ST_RUN;
                        pkt_q        <= dev_packet;
                        bytemode_q   <= dev_packet && !packet_blocks;
                        lba_q        <= lba;
                        store_dir    <= !dev_packet && (op_code != OP_READ);
                        kick         <= 1'b1;
                        status_ready <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (take) begin
                        if (rem_le0) begin
                            chunk_ack    <= 1'b1;
                            done         <= 1'b1;
                            status_ready <= !pkt_q;
                            state        <= ST_IDLE;
                        end else begin
                            store_req <= 1'b1;
                            store_off <= cur_off;
                            store_len <= issue_len;
                            state     <= ST_XFER;
                        end
                    end
                end
                ST_XFER: begin
                    if (store_err) begin
                        store_req <= 1'b0;
                        chunk_ack <= 1'b1;
                        error     <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (store_ack) begin
                        store_req <= 1'b0;
                        chunk_ack <= 1'b1;
                        if (bytemode_q || rem_le0) begin
                            done         <= 1'b1;
                            status_ready <= !pkt_q;
                            state        <= ST_IDLE;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Transfer-active flag seen by the channel.
    always_comb dma_active = (state != ST_IDLE);

    AST_KICK_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dma_active) |=> (kick && dma_active)); // R1

    AST_NO_KICK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_active |=> !kick); // R1

    AST_STALL_NOT_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_stall |-> (!store_req && !chunk_ack)); // R4

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !store_ack && !store_err) |=>
            (store_req && $stable(store_off) && $stable(store_len))); // R5

    AST_ACK_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && store_ack) |=> chunk_ack); // R5

    AST_DONE_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dma_active && chunk_ack)); // R7

    AST_ERROR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!done && !dma_active && !status_ready)); // R9

    AST_FLUSH_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack |-> !$past(store_req)); // R10

endmodule

// File: tb/tb_ide_dma_sequencer.sv
module tb_ide_dma_sequencer;

    localparam int LBA_W  = 20;
    localparam int SECT_W = 8;
    localparam int PKT_W  = 16;
    localparam int LEN_W  = 16;
    localparam int OFF_W  = LBA_W + 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              dev_packet = 1'b0;
    logic              packet_blocks = 1'b0;
    logic [1:0]        op_code = 2'd0;
    logic [LBA_W-1:0]  lba = '0;
    logic [SECT_W-1:0] sector_count = '0;
    logic [PKT_W-1:0]  packet_bytes = '0;
    logic              kick;
    logic              dma_active;
    logic              chunk_req = 1'b0;
    logic [LEN_W-1:0]  chunk_len = '0;
    logic              chunk_ack;
    logic              chunk_stall;
    logic              store_req;
    logic              store_dir;
    logic [OFF_W-1:0]  store_off;
    logic [LEN_W-1:0]  store_len;
    logic              store_ack = 1'b0;
    logic              store_err = 1'b0;
    logic              flush_req = 1'b0;
    logic              flush_ack;
    logic              done;
    logic              error;
    logic              status_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Bench model of the running transfer.
    longint m_rem;
    longint m_idx;
    longint m_lba;
    bit     m_pkt;
    bit     m_byte;
    bit     m_dir;

    always #5 clk = ~clk;

    ide_dma_sequencer #(
        .LBA_W (LBA_W), .SECT_W (SECT_W), .PKT_W (PKT_W), .LEN_W (LEN_W)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start (start), .dev_packet (dev_packet),
        .packet_blocks (packet_blocks), .op_code (op_code), .lba (lba),
        .sector_count (sector_count), .packet_bytes (packet_bytes),
        .kick (kick), .dma_active (dma_active), .chunk_req (chunk_req),
        .chunk_len (chunk_len), .chunk_ack (chunk_ack), .chunk_stall (chunk_stall),
        .store_req (store_req), .store_dir (store_dir), .store_off (store_off),
        .store_len (store_len), .store_ack (store_ack), .store_err (store_err),
        .flush_req (flush_req), .flush_ack (flush_ack), .done (done),
        .error (error), .status_ready (status_ready)
    );

    task automatic eq(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint exp_offset(input longint lb, input longint ix, input bit pkt);
        return (lb << (pkt ? 11 : 9)) + ix;
    endfunction

    function automatic longint exp_size(input bit pkt, input int ns, input int ps);
        return pkt ? longint'(ps) : longint'(ns) * 512;
    endfunction

    function automatic bit exp_dir(input bit pkt, input int op);
        return !pkt && (op != 0);
    endfunction

    // Start a transfer and check the kick (R1, R2 through the model).
    task automatic do_start(input bit pkt, input bit blk, input int op,
                            input longint lb, input int ns, input int ps);
        dev_packet    = pkt;
        packet_blocks = blk;
        op_code       = op[1:0];
        lba           = lb[LBA_W-1:0];
        sector_count  = ns[SECT_W-1:0];
        packet_bytes  = ps[PKT_W-1:0];
        start         = 1'b1;
        @(negedge clk);
        start = 1'b0;
        eq("R1 kick after start", longint'(kick), 1);
        eq("R1 dma_active after start", longint'(dma_active), 1);
        m_rem  = exp_size(pkt, ns, ps);
        m_idx  = 0;
        m_lba  = lb;
        m_pkt  = pkt;
        m_byte = pkt && !blk;
        m_dir  = exp_dir(pkt, op);
        @(negedge clk);
        eq("R1 kick is a single pulse", longint'(kick), 0);
    endtask

    // Offer one chunk and acknowledge its storage request; fin reports completion.
    task automatic do_chunk(input int len, output bit fin);
        longint elen;
        chunk_req = 1'b1;
        chunk_len = len[LEN_W-1:0];
        @(negedge clk);
        if (m_rem <= 0) begin
            eq("R7 no store when nothing remains", longint'(store_req), 0);
            eq("R7 done at request", longint'(done), 1);
            eq("R7 chunk_ack at request", longint'(chunk_ack), 1);
            eq("R7 status_ready by device type", longint'(status_ready), longint'(!m_pkt));
            chunk_req = 1'b0;
            @(negedge clk);
            fin = 1'b1;
            return;
        end
        elen = (m_byte && len > m_rem) ? m_rem : longint'(len);
        eq("R5 store_req raised", longint'(store_req), 1);
        eq("R3 store_off", longint'(store_off), exp_offset(m_lba, m_idx, m_pkt));
        eq(m_byte ? "R8 clamped store_len" : "R3 store_len", longint'(store_len), elen);
        eq("R6 store_dir", longint'(store_dir), longint'(m_dir));
        @(negedge clk);
        eq("R5 store_req held", longint'(store_req), 1);
        eq("R5 store_off stable", longint'(store_off), exp_offset(m_lba, m_idx, m_pkt));
        store_ack = 1'b1;
        @(negedge clk);
        store_ack = 1'b0;
        chunk_req = 1'b0;
        m_rem = m_rem - elen;
        m_idx = m_idx + elen;
        fin = m_byte || (m_rem <= 0);
        eq("R5 chunk_ack after store_ack", longint'(chunk_ack), 1);
        eq("R5 store_req dropped", longint'(store_req), 0);
        eq(m_byte ? "R8 done after single step" : "R7 done flag", longint'(done), longint'(fin));
        eq("R7 dma_active", longint'(dma_active), longint'(!fin));
        if (fin) eq("R7 status_ready by device type", longint'(status_ready), longint'(!m_pkt));
        @(negedge clk);
        eq("R5 chunk_ack single pulse", longint'(chunk_ack), 0);
    endtask

    // Run chunks of a fixed length until the transfer completes.
    task automatic run_fixed(input int len);
        bit f;
        f = 1'b0;
        while (!f) do_chunk(len, f);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit f;
        int seed;
        seed = int'($urandom(32'h5EED_1DE5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: outputs low after reset.
        eq("R11 reset outputs", longint'({kick, dma_active, chunk_ack, chunk_stall, store_req,
            store_dir, flush_ack, done, error, status_ready}), 0);
        eq("R11 reset store_off", longint'(store_off), 0);

        // R4: chunk before start is stalled, not consumed.
        chunk_req = 1'b1;
        chunk_len = 16'd100;
        @(negedge clk);
        @(negedge clk);
        eq("R4 chunk_stall while inactive", longint'(chunk_stall), 1);
        eq("R4 no store_req while inactive", longint'(store_req), 0);
        eq("R4 no chunk_ack while inactive", longint'(chunk_ack), 0);
        eq("R4 dma_active low", longint'(dma_active), 0);
        chunk_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        eq("R4 stall ends with request", longint'(chunk_stall), 0);

        // R2/R3/R6/R7: disk read, two exact sectors.
        do_start(1'b0, 1'b0, 0, 5, 2, 0);
        run_fixed(512);
        // Disk write with one oversize chunk: remaining goes negative.
        do_start(1'b0, 1'b0, 1, 77, 1, 0);
        run_fixed(600);
        // Disk trim, direction toward device.
        do_start(1'b0, 1'b0, 2, 1000, 3, 0);
        run_fixed(1024);
        // Packet device, block-based.
        do_start(1'b1, 1'b1, 0, 3, 0, 4096);
        run_fixed(2048);
        // R8: packet byte mode, clamp to the remainder.
        do_start(1'b1, 1'b0, 1, 9, 0, 300);
        run_fixed(1000);
        // R8: packet byte mode, chunk smaller than remainder still finishes.
        do_start(1'b1, 1'b0, 0, 9, 0, 3000);
        run_fixed(256);
        // R7: zero-length disk transfer completes at the first request.
        do_start(1'b0, 1'b0, 0, 12, 0, 0);
        run_fixed(512);

        // R1: a second start while active is ignored.
        do_start(1'b0, 1'b0, 0, 7, 2, 0);
        dev_packet = 1'b1;
        lba        = 20'd99;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        eq("R1 no kick for start while active", longint'(kick), 0);
        run_fixed(512);

        // R9: storage error aborts the transfer.
        do_start(1'b0, 1'b0, 1, 40, 4, 0);
        chunk_req = 1'b1;
        chunk_len = 16'd512;
        @(negedge clk);
        eq("R9 store_req before error", longint'(store_req), 1);
        store_err = 1'b1;
        @(negedge clk);
        store_err = 1'b0;
        chunk_req = 1'b0;
        eq("R9 error pulse", longint'(error), 1);
        eq("R9 no done on abort", longint'(done), 0);
        eq("R9 dma_active cleared", longint'(dma_active), 0);
        eq("R9 status_ready stays clear", longint'(status_ready), 0);
        @(negedge clk);
        eq("R9 error single pulse", longint'(error), 0);

        // R10: flush held off while a storage request is outstanding.
        do_start(1'b0, 1'b0, 0, 2, 1, 0);
        chunk_req = 1'b1;
        chunk_len = 16'd512;
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        eq("R10 flush_ack held while store pending", longint'(flush_ack), 0);
        store_ack = 1'b1;
        @(negedge clk);
        store_ack = 1'b0;
        chunk_req = 1'b0;
        eq("R10 done with flush pending", longint'(done), 1);
        @(negedge clk);
        eq("R10 flush_ack once idle", longint'(flush_ack), 1);
        flush_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        eq("R10 flush_ack drops with request", longint'(flush_ack), 0);

        // Random transfers over all device types, commands and chunk sizes.
        for (int t = 0; t < 30; t++) begin
            bit  pk;
            bit  bl;
            int  op;
            int  ns;
            int  ps;
            longint lb;
            pk = 1'($urandom_range(0, 1));
            bl = 1'($urandom_range(0, 1));
            op = int'($urandom_range(0, 2));
            ns = int'($urandom_range(0, 7));
            ps = int'($urandom_range(0, 5000));
            lb = longint'($urandom_range(0, (1 << LBA_W) - 1));
            do_start(pk, bl, op, lb, ns, ps);
            f = 1'b0;
            while (!f) do_chunk(int'($urandom_range(64, 1500)), f);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule